// File: doc/BRIEF.md
# Calibrated Per-Byte Read-Valid Aligner

DDR2 devices send read data back with no valid indication. This block rebuilds one from the controller's Read command. It waits out the CAS latency and then holds a raw enable for as many fabric cycles as the burst occupies. The raw enable then feeds a shared shift chain. Each data byte lane picks its own tap on that chain, and the chosen tap is registered onto that lane's `rden_byte` output. That output is meant to drive the write enable of the read-data FIFO for both the rising-edge and falling-edge data words of the lane.

The tap for each lane is found by calibration. After initialization the controller writes a known pattern and pulses `cal_start`. It then issues a series of dummy reads. Each dummy read tests one candidate tap in every lane that is still searching. The lane compares its captured bytes in the cycle where that candidate's enable would first be high. The first candidate that matches is locked. When every lane has locked, `cal_done` rises. A lane that runs past its last candidate raises `cal_err` and keeps `cal_done` low. Calibration runs once per reset.

Top module: `rd_valid_align`

## Requirements
- R1: For a Read command sampled in cycle t, lane b's `rden_byte[b]` first goes high in cycle t + `cas_lat` + 1 + d_b. Here d_b is that lane's current delay, and `cas_lat` lies in 2..6.
- R2: The enable stays high for 2 consecutive cycles when `burst8` is 0 (burst of 4) and for 4 consecutive cycles when `burst8` is 1 (burst of 8). It is low otherwise.
- R3: Each lane applies its own delay of 0..7 cycles. Lane b's delay is reported in `cal_dly[3b+2:3b]`.
- R4: After reset and before calibration locks anything, every lane uses delay 0.
- R5: After `cal_start`, each dummy read tests the current candidate of every unresolved lane. The test falls in the cycle where that candidate's enable would first be high. A match means the lane's rising byte equals 0xA5 and its falling byte equals 0x5A. A match locks the candidate; a mismatch moves the candidate up by one. Candidates start at 0.
- R6: `cal_done` rises once all lanes have locked and stays high until reset. Any later `cal_start` is ignored, and the locked delays do not change.
- R7: A lane that mismatches at candidate 7 is marked failed and stays at delay 7. `cal_err` then goes high and `cal_done` stays low.
- R8: Reset clears `rden_byte`, `cal_done`, `cal_err` and every `cal_dly` field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | High for one cycle when a Read command is issued |
| cas_lat | input | 3 | CAS latency in cycles, 2..6 |
| burst8 | input | 1 | 1 selects burst of 8 (4-cycle enable); 0 selects burst of 4 (2-cycle enable) |
| cal_start | input | 1 | Begins calibration (honoured once per reset) |
| rd_rise | input | 16 | Deserialized rising-edge data, byte b at [8b+7:8b] |
| rd_fall | input | 16 | Deserialized falling-edge data, byte b at [8b+7:8b] |
| rden_byte | output | 2 | Aligned read enable per byte lane |
| cal_dly | output | 6 | Selected delay per lane, 3 bits each |
| cal_done | output | 1 | All lanes calibrated |
| cal_err | output | 1 | At least one lane found no matching delay |

## Verification
If a lane's candidate counter stepped wrongly or locked on the wrong compare cycle, `cal_dly` would show a value other than the lane's true data delay. That would be visible as soon as the dummy reads end, and every later read window for that lane would then be shifted by the same error. A fault in the latency shift register or the burst counter moves or widens every enable window. That shows up on the first read after reset, because the bench samples each cycle of the window. A lost once-only latch shows up as changed delays after a second `cal_start`.

// File: rtl/rdal_pkg.sv
package rdal_pkg;
  // Fabric cycles the enable must span for the selected burst.
  function automatic int burst_cycles(input logic bl8);
    return bl8 ? 4 : 2;
  endfunction
endpackage

// File: rtl/rdal_lat_gen.sv
module rdal_lat_gen #(
  parameter int CL_MAX = 6,
  localparam int CL_W = $clog2(CL_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_cmd,
  input  logic [CL_W-1:0] cas_lat,
  input  logic            burst8,
  output logic            raw_en
);
  // cmd_hist[k] is high when a Read was issued k+1 cycles ago
  logic [CL_MAX-2:0] cmd_hist;
  logic [1:0]        remain;
  logic              start;

  always_comb begin
    start = 1'b0;
    for (int k = 0; k <= CL_MAX - 2; k++) begin
      if (cas_lat == CL_W'(k + 2)) start = cmd_hist[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_hist <= '0;
      remain   <= '0;
      raw_en   <= 1'b0;
    end else begin
      cmd_hist <= {cmd_hist[CL_MAX-3:0], rd_cmd};
      if (start) begin
        remain <= 2'(rdal_pkg::burst_cycles(burst8) - 1);
        raw_en <= 1'b1;
      end else if (remain != 2'd0) begin
        remain <= remain - 2'd1;
        raw_en <= 1'b1;
      end else begin
        raw_en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdal_dly_chain.sv
module rdal_dly_chain #(
  parameter int DLY_MAX = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_en,
  output logic [DLY_MAX+1:0] taps
);
  // One extra stage beyond the last usable tap feeds edge detection.
  logic [DLY_MAX+1:1] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[DLY_MAX:1], raw_en};
  end

  assign taps = {stage, raw_en};
endmodule

// File: rtl/rdal_lane_cal.sv
module rdal_lane_cal #(
  parameter int         DLY_MAX  = 7,
  parameter logic [7:0] PAT_RISE = 8'hA5,
  parameter logic [7:0] PAT_FALL = 8'h5A,
  localparam int DLY_W = $clog2(DLY_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DLY_MAX+1:0] taps,
  input  logic               cal_go,
  input  logic [7:0]         rise_byte,
  input  logic [7:0]         fall_byte,
  output logic               rden,
  output logic [DLY_W-1:0]   dly,
  output logic               ok,
  output logic               bad
);
  logic [DLY_W-1:0] cand;
  logic             busy;
  logic             probe_q;
  logic             tap_cur;
  logic             tap_nxt;
  logic             match;

  always_comb begin
    tap_cur = 1'b0;
    tap_nxt = 1'b0;
    for (int i = 0; i <= DLY_MAX; i++) begin
      if (cand == DLY_W'(i)) begin
        tap_cur = taps[i];
        tap_nxt = taps[i+1];
      end
    end
  end

  assign match = (rise_byte == PAT_RISE) && (fall_byte == PAT_FALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cand    <= '0;
      busy    <= 1'b0;
      probe_q <= 1'b0;
      ok      <= 1'b0;
      bad     <= 1'b0;
      rden    <= 1'b0;
    end else begin
      rden    <= tap_cur;
      // first cycle of the candidate window, registered to line up with rden
      probe_q <= busy & tap_cur & ~tap_nxt;
      if (cal_go) begin
        busy <= 1'b1;
        cand <= '0;
      end else if (busy && probe_q) begin
        if (match) begin
          ok   <= 1'b1;
          busy <= 1'b0;
        end else if (cand == DLY_W'(DLY_MAX)) begin
          bad  <= 1'b1;
          busy <= 1'b0;
        end else begin
          cand <= cand + 1'b1;
        end
      end
    end
  end

  assign dly = cand;

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ok |=> (ok && $stable(cand)));
  p_fail_at_last_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bad) |-> (cand == DLY_W'(DLY_MAX)));
  p_ok_bad_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(ok && bad));
endmodule

// File: rtl/rd_valid_align.sv
module rd_valid_align #(
  parameter int         NUM_BYTES = 2,
  parameter int         CL_MAX    = 6,
  parameter int         DLY_MAX   = 7,
  parameter logic [7:0] PAT_RISE  = 8'hA5,
  parameter logic [7:0] PAT_FALL  = 8'h5A,
  localparam int CL_W  = $clog2(CL_MAX + 1),
  localparam int DLY_W = $clog2(DLY_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_cmd,
  input  logic [CL_W-1:0]          cas_lat,
  input  logic                     burst8,
  input  logic                     cal_start,
  input  logic [8*NUM_BYTES-1:0]   rd_rise,
  input  logic [8*NUM_BYTES-1:0]   rd_fall,
  output logic [NUM_BYTES-1:0]     rden_byte,
  output logic [NUM_BYTES*DLY_W-1:0] cal_dly,
  output logic                     cal_done,
  output logic                     cal_err
);
  logic               raw_en;
  logic [DLY_MAX+1:0] taps;
  logic               cal_used;
  logic               cal_go;
  logic [NUM_BYTES-1:0] lane_ok;
  logic [NUM_BYTES-1:0] lane_bad;

  rdal_lat_gen #(.CL_MAX(CL_MAX)) u_lat (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .cas_lat(cas_lat),
    .burst8(burst8), .raw_en(raw_en)
  );

  rdal_dly_chain #(.DLY_MAX(DLY_MAX)) u_chain (
    .clk(clk), .rst(rst), .raw_en(raw_en), .taps(taps)
  );

  // calibration is honoured once per reset
  assign cal_go = cal_start & ~cal_used;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_used <= 1'b0;
      cal_done <= 1'b0;
      cal_err  <= 1'b0;
    end else begin
      if (cal_go) cal_used <= 1'b1;
      cal_done <= &lane_ok;
      cal_err  <= |lane_bad;
    end
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    rdal_lane_cal #(
      .DLY_MAX(DLY_MAX), .PAT_RISE(PAT_RISE), .PAT_FALL(PAT_FALL)
    ) u_lane (
      .clk(clk), .rst(rst), .taps(taps), .cal_go(cal_go),
      .rise_byte(rd_rise[8*b +: 8]), .fall_byte(rd_fall[8*b +: 8]),
      .rden(rden_byte[b]), .dly(cal_dly[DLY_W*b +: DLY_W]),
      .ok(lane_ok[b]), .bad(lane_bad[b])
    );
  end

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> cal_done);
  p_err_blocks_done_r7: assert property (@(posedge clk) disable iff (rst)
    cal_err |-> !cal_done);
endmodule

// File: tb/test_rd_valid_align.sv
module test_rd_valid_align;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_cmd = 1'b0;
  logic [2:0]    cas_lat = 3'd4;
  logic          burst8 = 1'b0;
  logic          cal_start = 1'b0;
  logic [8*NB-1:0] rd_rise = '0;
  logic [8*NB-1:0] rd_fall = '0;
  logic [NB-1:0] rden_byte;
  logic [3*NB-1:0] cal_dly;
  logic          cal_done;
  logic          cal_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int cmd_t = -1;
  int cur_cl = 4;
  int lane_d [NB];
  int exp_d  [NB];
  bit finished = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) cyc = cyc + 1;

  rd_valid_align i_rd_valid_align (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .cas_lat(cas_lat), .burst8(burst8),
    .cal_start(cal_start), .rd_rise(rd_rise), .rd_fall(rd_fall),
    .rden_byte(rden_byte), .cal_dly(cal_dly), .cal_done(cal_done), .cal_err(cal_err)
  );

  // model of returned data: pattern on the first word, filler afterwards
  always @(negedge clk) begin
    for (int b = 0; b < NB; b++) begin
      int first;
      first = cmd_t + cur_cl + 1 + lane_d[b];
      if (cmd_t >= 0 && cyc == first) begin
        rd_rise[8*b +: 8] <= 8'hA5;
        rd_fall[8*b +: 8] <= 8'h5A;
      end else if (cmd_t >= 0 && cyc > first && cyc < first + 4) begin
        rd_rise[8*b +: 8] <= 8'h3C;
        rd_fall[8*b +: 8] <= 8'hC3;
      end else begin
        rd_rise[8*b +: 8] <= 8'h00;
        rd_fall[8*b +: 8] <= 8'h00;
      end
    end
  end

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // one read; when chk is set, every cycle of each lane's window is compared
  task automatic do_read(input int cl, input bit bl8, input bit chk, input string req);
    int len;
    int err [NB];
    int bad_cyc [NB];
    len = bl8 ? 4 : 2;
    @(negedge clk);
    cas_lat = 3'(cl);
    burst8 = bl8;
    cur_cl = cl;
    rd_cmd = 1'b1;
    cmd_t = cyc;
    for (int b = 0; b < NB; b++) begin err[b] = 0; bad_cyc[b] = -1; end
    for (int n = 1; n <= 24; n++) begin
      @(negedge clk);
      rd_cmd = 1'b0;
      for (int b = 0; b < NB; b++) begin
        int s;
        bit e;
        s = cmd_t + cl + 1 + exp_d[b];
        e = (cyc >= s) && (cyc < s + len);
        if (rden_byte[b] !== e && bad_cyc[b] < 0) begin
          err[b] = 1;
          bad_cyc[b] = cyc - cmd_t;
        end
      end
    end
    cmd_t = -1;
    if (chk)
      for (int b = 0; b < NB; b++) begin
        n_chk++;
        if (err[b] != 0) begin
          n_bad++;
          $display("FAIL %s lane %0d cl %0d bl8 %0d: actual enable wrong at offset %0d, expected window %0d..%0d",
                   req, b, cl, bl8, bad_cyc[b], cl + 1 + exp_d[b], cl + len + exp_d[b]);
        end
      end
  endtask

  task automatic run_cal(input int d0, input int d1);
    lane_d[0] = d0;
    lane_d[1] = d1;
    @(negedge clk);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    for (int r = 0; r < 12; r++) do_read(4, 1'b0, 1'b0, "R5");
  endtask

  initial begin
    lane_d[0] = 0; lane_d[1] = 0;
    exp_d[0] = 0;  exp_d[1] = 0;
    do_reset();
    // R8 reset state
    check(rden_byte, 0, "R8 rden");
    check(cal_done, 0, "R8 done");
    check(cal_err, 0, "R8 err");
    check(cal_dly, 0, "R8 dly");

    // R1 R2 R4: uncalibrated sweep over latency and burst, delay 0
    for (int cl = 2; cl <= 6; cl++)
      for (int bl = 0; bl < 2; bl++)
        do_read(cl, bl[0], 1'b1, "R1/R2/R4");

    // R5 R3: lanes with different data delays
    run_cal(3, 5);
    check(cal_dly[2:0], 3, "R5 lane0 dly");
    check(cal_dly[5:3], 5, "R5 lane1 dly");
    check(cal_done, 1, "R6 done");
    check(cal_err, 0, "R7 err low");
    exp_d[0] = 3; exp_d[1] = 5;
    do_read(3, 1'b0, 1'b1, "R3");
    do_read(5, 1'b1, 1'b1, "R3");
    do_read(6, 1'b0, 1'b1, "R3");

    // R6: second calibration request ignored
    run_cal(1, 1);
    check(cal_dly[2:0], 3, "R6 lane0 fixed");
    check(cal_dly[5:3], 5, "R6 lane1 fixed");
    check(cal_done, 1, "R6 done held");
    do_read(2, 1'b1, 1'b1, "R6");

    // R5 boundaries: delays 0 and 7
    do_reset();
    exp_d[0] = 0; exp_d[1] = 0;
    run_cal(0, 7);
    check(cal_dly[2:0], 0, "R5 lane0 min");
    check(cal_dly[5:3], 7, "R5 lane1 max");
    check(cal_done, 1, "R5 done");
    exp_d[0] = 0; exp_d[1] = 7;
    do_read(4, 1'b1, 1'b1, "R3");

    // R7: lane 1 never matches
    do_reset();
    run_cal(2, 9);
    check(cal_dly[2:0], 2, "R7 lane0 dly");
    check(cal_dly[5:3], 7, "R7 lane1 stuck");
    check(cal_err, 1, "R7 err");
    check(cal_done, 0, "R7 done low");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule